// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Controller

This block collects a parameterised set of interrupt request lines plus one non-maskable line. It decides when the processor core must enter a handler and which vector number that handler has. Each line carries a priority value, an enable bit and a trigger mode (edge or level), all set through a simple write port. One global grouping value splits every priority value into a preemption part (the high-order bits) and a subpriority part (the low-order bits). A global threshold blocks the less urgent preemption levels.

The controller keeps a stack of the preemption levels of the handlers now running. A pending request interrupts the running handler only when its preemption level is strictly more urgent than the level on top of that stack. Subpriority and line index only order requests that are waiting together. The core signals the end of a handler with an end-of-interrupt strobe, which pops the stack. An end-of-interrupt with nothing active sets a sticky error flag. Request inputs are asynchronous and pass through two-flop synchronisers.

Top module: `nic_top`

## Requirements
- R1: After reset there is no take strobe and the error flag is low. Every line is disabled, in edge mode and at the least urgent priority (all ones). The grouping makes all bits preemption bits and the threshold passes every level. An asserted request therefore produces no take.
- R2: With grouping value G (0..PRIO_W), the preemption level is the priority with its low PRIO_W-G bits cleared. G=0 puts every line on one level, so nothing nests. G=PRIO_W makes every priority value its own level.
- R3: With no handler active, the winner is the eligible request with the numerically lowest priority value, and ties go to the lowest line index. A take is a one-cycle `irq_take_o` pulse, with `irq_vec_o` holding the line index in that same cycle.
- R4: A line request is taken while a handler is active only if its preemption level is numerically lower than the active level on top of the stack.
- R5: A request at the same preemption level as the active handler is never taken while that handler runs, whatever its subpriority.
- R6: A request that arrives during a handler stays pending and is taken after end-of-interrupt makes it the most urgent eligible request. Same-level waiters are taken in subpriority order.
- R7: A disabled line is never taken. An edge that arrived while the line was disabled stays pending and is taken once the line is enabled.
- R8: A line request passes the threshold only when its preemption level value is numerically below the threshold register. A threshold of 0 blocks every line, and 2^PRIO_W passes all.
- R9: The non-maskable input uses vector NUM_LINES. It ignores enables and threshold, beats every line and preempts any line handler. It does not preempt another non-maskable handler; a second edge waits until that handler ends.
- R10: In edge mode each rising edge gives exactly one take. In level mode the line is taken again after every end-of-interrupt for as long as the input stays high.
- R11: End-of-interrupt pops one stack entry. If a take happens in the same cycle, the new level replaces the top entry, and arbitration in that cycle uses the level before the pop.
- R12: An end-of-interrupt while the stack is empty changes nothing but sets `eoi_err_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_LINES | Asynchronous request lines |
| nmi_i | input | 1 | Asynchronous non-maskable request, edge triggered |
| cfg_line_we | input | 1 | Write strobe for one line's settings |
| cfg_line_sel | input | IDX_W | Line selected by the write |
| cfg_line_prio | input | PRIO_W | Priority value (lower is more urgent) |
| cfg_line_en | input | 1 | Line enable |
| cfg_line_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| cfg_glob_we | input | 1 | Write strobe for grouping and threshold |
| cfg_group | input | GRP_W | Number of preemption bits |
| cfg_thresh | input | PRIO_W+1 | Threshold level |
| eoi_i | input | 1 | End-of-interrupt strobe from the core |
| irq_take_o | output | 1 | One-cycle strobe: enter a handler |
| irq_vec_o | output | VEC_W | Vector number presented with the strobe |
| eoi_err_o | output | 1 | Sticky flag for end-of-interrupt with an empty stack |

## Verification
An end-of-interrupt and a preempting take can land on the same clock edge, so the pop and the push of the active-level stack meet. The bench provokes this by raising an urgent edge request a fixed number of cycles before it drives the end-of-interrupt strobe, timing it from the synchroniser and pending-register latency. It judges the result by the take vector in that exact cycle, then by one legal end-of-interrupt, and then by the error flag rising on the next one. A wrong stack depth shows up either as a missing error or as an early one.

// File: rtl/nic_pkg.sv
// Shared types for the nested interrupt controller.
package nic_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/nic_sync_edge.sv
// Two-flop synchroniser with a rising-edge detector per bit.
// Assumes inputs are asynchronous, glitch-free levels; rise_o pulses one cycle.
module nic_sync_edge #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic s1, s2, s3;

        // Synchronise the input and keep one older copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= async_i[b];
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign sync_o[b] = s2;
        assign rise_o[b] = s2 & ~s3;

        AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rise_o[b] |=> !rise_o[b]); // R10
    end
endmodule

// File: rtl/nic_arbiter.sv
// Picks the eligible line with the lowest priority value, lowest index on ties.
// Assumes the full priority value orders preemption level first, subpriority second.
module nic_arbiter #(
    parameter int N     = 8,
    parameter int PW    = 3,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig_i,
    input  logic [PW-1:0] prio_i [N],
    output logic          valid_o,
    output logic [IW-1:0] idx_o,
    output logic [PW-1:0] prio_o
);
    // Linear scan; strict compare keeps the lowest index among equals.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '1;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[i];
            end
        end
    end

    AST_WIN_ELIG: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> elig_i[idx_o]); // R3
endmodule

// File: rtl/nic_level_stack.sv
// Stack of active preemption levels; top is the level now running.
// Assumes a push is only issued for a level strictly more urgent than the top,
// so DEPTH = number of levels + 1 never overflows. Empty top reads all ones.
module nic_level_stack #(
    parameter int DEPTH = 9,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [LW-1:0] push_lvl_i,
    input  logic          pop_i,
    output logic [LW-1:0] top_o,
    output logic          empty_o,
    output logic          err_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic [LW-1:0] stk [DEPTH];
    logic [CW-1:0] cnt;
    logic          pop_ok;

    assign pop_ok  = pop_i && (cnt != '0);
    assign empty_o = (cnt == '0);
    assign top_o   = empty_o ? '1 : stk[AW'(cnt - CW'(1))];

    // Push, pop or replace the top; flag a pop with nothing active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            err_o <= 1'b0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '1;
        end else begin
            if (pop_i && cnt == '0) err_o <= 1'b1;
            if (push_i && pop_ok) begin
                stk[AW'(cnt - CW'(1))] <= push_lvl_i;
            end else if (push_i) begin
                stk[AW'(cnt)] <= push_lvl_i;
                cnt           <= cnt + CW'(1);
            end else if (pop_ok) begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (push_i && !pop_ok) |-> cnt < CW'(DEPTH)); // R4
    AST_PUSH_STRICT: assert property (@(posedge clk) disable iff (!rst_n) (push_i && !empty_o) |-> push_lvl_i < top_o); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o); // R12
endmodule

// File: rtl/nic_top.sv
// Nested interrupt controller with grouped priorities, threshold and one
// non-maskable input. Holds line configuration and pending state, arbitrates,
// compares the winner against the active-level stack and issues a registered
// take strobe with its vector. Stack levels: 0 = non-maskable, 1 + masked
// priority for lines, all ones = idle.
module nic_top #(
    parameter int NUM_LINES = 8,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int VEC_W    = $clog2(NUM_LINES + 1),
    localparam int GRP_W    = $clog2(PRIO_W + 1),
    localparam int LVL_W    = PRIO_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 nmi_i,
    input  logic                 cfg_line_we,
    input  logic [IDX_W-1:0]     cfg_line_sel,
    input  logic [PRIO_W-1:0]    cfg_line_prio,
    input  logic                 cfg_line_en,
    input  logic                 cfg_line_level,
    input  logic                 cfg_glob_we,
    input  logic [GRP_W-1:0]     cfg_group,
    input  logic [LVL_W-1:0]     cfg_thresh,
    input  logic                 eoi_i,
    output logic                 irq_take_o,
    output logic [VEC_W-1:0]     irq_vec_o,
    output logic                 eoi_err_o
);
    import nic_pkg::*;

    localparam int          DEPTH   = (1 << PRIO_W) + 1;
    localparam [VEC_W-1:0]  NMI_VEC = VEC_W'(NUM_LINES);

    logic [PRIO_W-1:0]    prio_q [NUM_LINES];
    logic [NUM_LINES-1:0] en_q;
    trig_e                mode_q [NUM_LINES];
    logic [NUM_LINES-1:0] pend_q;
    logic                 nmi_pend_q;
    logic [GRP_W-1:0]     group_q;
    logic [LVL_W-1:0]     thr_q;

    logic [NUM_LINES:0]   sync_w, rise_w;
    logic [NUM_LINES-1:0] pend_eff, elig;
    logic [LVL_W-1:0]     lvl_of [NUM_LINES];
    logic [GRP_W-1:0]     grp_eff;
    logic [PRIO_W-1:0]    pre_mask;

    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    logic [PRIO_W-1:0]    win_prio;
    logic [LVL_W-1:0]     win_lvl;

    logic [LVL_W-1:0]     stk_top;
    logic                 stk_empty;
    logic                 nmi_go, line_go, take_now;
    logic [LVL_W-1:0]     push_lvl;

    nic_sync_edge #(.WIDTH(NUM_LINES + 1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nmi_i, req_i}),
        .sync_o  (sync_w),
        .rise_o  (rise_w)
    );

    // Per-line settings, written one line at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                prio_q[i] <= '1;
                mode_q[i] <= TRIG_EDGE;
            end
        end else if (cfg_line_we) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (cfg_line_sel == IDX_W'(i)) begin
                    prio_q[i] <= cfg_line_prio;
                    en_q[i]   <= cfg_line_en;
                    mode_q[i] <= trig_e'(cfg_line_level);
                end
            end
        end
    end

    // Global grouping and threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            group_q <= GRP_W'(PRIO_W);
            thr_q   <= LVL_W'(1 << PRIO_W);
        end else if (cfg_glob_we) begin
            group_q <= cfg_group;
            thr_q   <= cfg_thresh;
        end
    end

    // Clamp the grouping and build the mask that keeps only preemption bits.
    always_comb begin
        grp_eff = (group_q > GRP_W'(PRIO_W)) ? GRP_W'(PRIO_W) : group_q;
        for (int b = 0; b < PRIO_W; b++) begin
            pre_mask[b] = (b + int'(grp_eff)) >= PRIO_W;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // Effective request, level value and eligibility of one line.
        always_comb begin
            pend_eff[i] = (mode_q[i] == TRIG_LEVEL) ? sync_w[i] : pend_q[i];
            lvl_of[i]   = {1'b0, prio_q[i] & pre_mask};
            elig[i]     = pend_eff[i] && en_q[i] && (lvl_of[i] < thr_q);
        end
    end

    nic_arbiter #(.N(NUM_LINES), .PW(PRIO_W), .IW(IDX_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig_i  (elig),
        .prio_i  (prio_q),
        .valid_o (win_valid),
        .idx_o   (win_idx),
        .prio_o  (win_prio)
    );

    // Decide whether a take happens this cycle and which level it pushes.
    always_comb begin
        win_lvl  = {1'b0, win_prio & pre_mask} + LVL_W'(1);
        nmi_go   = nmi_pend_q && (stk_top != '0);
        line_go  = win_valid && (win_lvl < stk_top) && !nmi_go;
        take_now = nmi_go || line_go;
        push_lvl = nmi_go ? '0 : win_lvl;
    end

    // Edge pending bits: a new edge sets, a take clears, level mode holds none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            nmi_pend_q <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (mode_q[i] == TRIG_LEVEL)                     pend_q[i] <= 1'b0;
                else if (rise_w[i])                              pend_q[i] <= 1'b1;
                else if (line_go && win_idx == IDX_W'(i))        pend_q[i] <= 1'b0;
            end
            if (rise_w[NUM_LINES])  nmi_pend_q <= 1'b1;
            else if (nmi_go)        nmi_pend_q <= 1'b0;
        end
    end

    nic_level_stack #(.DEPTH(DEPTH), .LW(LVL_W)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take_now),
        .push_lvl_i (push_lvl),
        .pop_i      (eoi_i),
        .top_o      (stk_top),
        .empty_o    (stk_empty),
        .err_o      (eoi_err_o)
    );

    // Register the take strobe and its vector toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take_o <= 1'b0;
            irq_vec_o  <= '0;
        end else begin
            irq_take_o <= take_now;
            irq_vec_o  <= nmi_go ? NMI_VEC : VEC_W'(win_idx);
        end
    end

    AST_TAKE_PUSHES: assert property (@(posedge clk) disable iff (!rst_n) irq_take_o |-> !stk_empty); // R11
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) irq_take_o |-> irq_vec_o <= NMI_VEC); // R3
    AST_NMI_TOP: assert property (@(posedge clk) disable iff (!rst_n) (irq_take_o && irq_vec_o == NMI_VEC) |-> stk_top == '0); // R9
    AST_EN_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take_o && irq_vec_o != NMI_VEC) |-> ((($past(en_q) >> irq_vec_o) & NUM_LINES'(1)) != '0)); // R7
endmodule

// File: tb/tb_nic_top.sv
module tb_nic_top;
    localparam int N  = 8;
    localparam int PW = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         nmi = 1'b0;
    logic         lwe = 1'b0;
    logic [2:0]   lsel = '0;
    logic [PW-1:0] lprio = '0;
    logic         len = 1'b0;
    logic         llev = 1'b0;
    logic         gwe = 1'b0;
    logic [1:0]   grp = '0;
    logic [3:0]   thr = '0;
    logic         eoi = 1'b0;
    logic         take;
    logic [3:0]   vec;
    logic         err;

    int n_chk = 0;
    int n_fail = 0;
    logic [PW-1:0] m_prio [N];

    nic_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .nmi_i(nmi),
        .cfg_line_we(lwe), .cfg_line_sel(lsel), .cfg_line_prio(lprio),
        .cfg_line_en(len), .cfg_line_level(llev),
        .cfg_glob_we(gwe), .cfg_group(grp), .cfg_thresh(thr),
        .eoi_i(eoi), .irq_take_o(take), .irq_vec_o(vec), .eoi_err_o(err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        req = '0; nmi = 1'b0; eoi = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_line(input int i, input int p, input bit e, input bit lv);
        @(negedge clk);
        lwe = 1'b1; lsel = 3'(i); lprio = PW'(p); len = e; llev = lv;
        m_prio[i] = PW'(p);
        @(negedge clk) lwe = 1'b0;
    endtask

    task automatic wr_glob(input int g, input int t);
        @(negedge clk);
        gwe = 1'b1; grp = 2'(g); thr = 4'(t);
        @(negedge clk) gwe = 1'b0;
    endtask

    task automatic raise(input int i);
        @(negedge clk) req[i] = 1'b1;
    endtask

    task automatic drop_all();
        @(negedge clk) req = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_eoi();
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
    endtask

    task automatic wait_take(input int exp, input string tag);
        bit got = 1'b0;
        int v = -1;
        for (int k = 0; k < 12 && !got; k++) begin
            @(negedge clk);
            if (take) begin got = 1'b1; v = int'(vec); end
        end
        chk(got && v == exp, tag, v, exp);
    endtask

    task automatic no_take(input int n, input string tag);
        bit bad = 1'b0;
        int v = -1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (take && !bad) begin bad = 1'b1; v = int'(vec); end
        end
        chk(!bad, tag, v, -1);
    endtask

    function automatic int model_win(input logic [N-1:0] pm);
        int w = -1;
        for (int i = 0; i < N; i++)
            if (pm[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) m_prio[i] = '1;
        do_reset();
        @(negedge clk);
        chk(take == 1'b0, "R1 take after reset", int'(take), 0);
        chk(err == 1'b0, "R1 err after reset", int'(err), 0);
        raise(0);
        no_take(8, "R1 disabled line at reset");
        drop_all();
        wr_line(0, 2, 1'b1, 1'b0);
        wait_take(0, "R7 edge kept while disabled");
        pulse_eoi();

        // Grouping 1: one preemption bit; subpriority must not nest.
        wr_glob(1, 8);
        wr_line(1, 5, 1'b1, 1'b0);
        wr_line(2, 6, 1'b1, 1'b0);
        wr_line(4, 4, 1'b1, 1'b0);
        wr_line(5, 2, 1'b1, 1'b0);
        raise(1);
        wait_take(1, "R3 single request");
        raise(2); raise(4);
        no_take(8, "R5 better subpriority no preempt");
        raise(5);
        wait_take(5, "R4 more urgent level preempts");
        pulse_eoi();
        no_take(6, "R5 same level after return");
        pulse_eoi();
        wait_take(4, "R6 pending by subpriority");
        pulse_eoi();
        wait_take(2, "R6 last pending");
        pulse_eoi();
        drop_all();

        // Grouping 3: every value is a level.
        wr_glob(3, 8);
        raise(1);
        wait_take(1, "R2 g3 first");
        raise(4);
        wait_take(4, "R2 g3 nests");
        pulse_eoi(); pulse_eoi();
        drop_all();

        // Grouping 0: no nesting at all.
        wr_glob(0, 8);
        raise(1);
        wait_take(1, "R2 g0 first");
        raise(5);
        no_take(8, "R2 g0 no nesting");
        pulse_eoi();
        wait_take(5, "R2 g0 after eoi");
        pulse_eoi();
        drop_all();

        // Threshold.
        wr_glob(3, 3);
        wr_line(3, 3, 1'b1, 1'b0);
        wr_line(4, 2, 1'b1, 1'b0);
        raise(3);
        no_take(8, "R8 level at threshold blocked");
        raise(4);
        wait_take(4, "R8 level below threshold");
        pulse_eoi();
        wr_glob(3, 8);
        wait_take(3, "R8 released by threshold");
        pulse_eoi();
        drop_all();

        // Non-maskable line.
        wr_glob(3, 0);
        wr_line(1, 0, 1'b1, 1'b0);
        raise(1);
        no_take(8, "R8 threshold zero blocks all");
        @(negedge clk) nmi = 1'b1;
        wait_take(8, "R9 nmi bypasses threshold");
        nmi = 1'b0;
        wr_glob(3, 8);
        no_take(8, "R9 line cannot preempt nmi");
        @(negedge clk) nmi = 1'b1;
        no_take(8, "R9 nmi does not nest");
        nmi = 1'b0;
        pulse_eoi();
        wait_take(8, "R9 second nmi after eoi");
        pulse_eoi();
        wait_take(1, "R4 line after nmi ends");
        pulse_eoi();
        drop_all();

        // Trigger modes.
        wr_line(6, 3, 1'b1, 1'b1);
        raise(6);
        wait_take(6, "R10 level first");
        no_take(6, "R10 level no self nest");
        pulse_eoi();
        wait_take(6, "R10 level retrigger");
        @(negedge clk) req[6] = 1'b0;
        no_take(6, "R10 level released");
        pulse_eoi();
        no_take(6, "R10 level gone");
        wr_line(6, 3, 1'b1, 1'b0);
        raise(6);
        wait_take(6, "R10 edge once");
        pulse_eoi();
        no_take(6, "R10 edge no retrigger");
        drop_all();

        // Random arbitration against the model.
        do_reset();
        for (int it = 0; it < 30; it++) begin
            logic [N-1:0] pm;
            int w;
            wr_glob(int'($urandom % 4), 8);
            for (int i = 0; i < N; i++) wr_line(i, int'($urandom % 8), 1'b1, 1'b0);
            pm = N'($urandom % 255 + 1);
            @(negedge clk) req = pm;
            while (pm != '0) begin
                w = model_win(pm);
                wait_take(w, "R3 random winner");
                pm[w] = 1'b0;
                pulse_eoi();
            end
            drop_all();
        end

        // End-of-interrupt and take in the same cycle, then spurious end.
        do_reset();
        wr_glob(3, 8);
        wr_line(0, 6, 1'b1, 1'b0);
        wr_line(1, 1, 1'b1, 1'b0);
        raise(0);
        wait_take(0, "R11 setup");
        drop_all();
        @(negedge clk) req[1] = 1'b1;
        repeat (3) @(negedge clk);
        eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
        chk(take == 1'b1 && vec == 4'd1, "R11 take with eoi", int'(vec), 1);
        no_take(4, "R11 no extra take");
        pulse_eoi();
        chk(err == 1'b0, "R11 one entry left", int'(err), 0);
        pulse_eoi();
        chk(err == 1'b1, "R12 spurious eoi", int'(err), 1);
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R12 sticky", int'(err), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule